// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the addressing fields of a register-based instruction into an operand location. A request carries a 3-bit mode, a 3-bit register number and a 2-bit operand size, and is launched by a one-cycle start strobe. The unit reads the current contents of the eight 32-bit address registers from a flattened input bus. One clock later it reports one of three results. The first is a register-operand selector, used when the operand sits in a data or address register. The second is a 32-bit memory address. The third is an illegal-mode flag.

For the two auto-stepping modes the unit also drives a write-back port: a register number, the stepped pointer value and a write enable. The surrounding register file uses this port to update the pointer. The step size follows the operand size. The stack pointer (address register 7) never moves by a single byte, so it stays on an even address. None of the five handled modes uses instruction extension words, so the extension-word count is always reported as zero.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o`, `illegal_o` and `wb_en_o` are low.
- R2: Mode 000 gives a register operand: `mem_o`=0, `opnd_sel_o`={1'b0, register number}, and no write-back.
- R3: Mode 001 gives a register operand: `mem_o`=0, `opnd_sel_o`={1'b1, register number}, and no write-back.
- R4: Mode 010 issues `addr_o` equal to the selected address register, with `mem_o`=1 and no write-back.
- R5: Mode 011 issues the current pointer as `addr_o`, and writes back the pointer plus the step to the same register with `wb_en_o`=1.
- R6: Mode 100 subtracts the step from the pointer, then issues the result as `addr_o` and writes back the same result with `wb_en_o`=1.
- R7: The size code selects the step: 00 (byte) steps by 1, 01 (word) by 2 and 10 (long) by 4.
- R8: When the register number is 7 and the size is byte, modes 011 and 100 step by 2.
- R9: `ext_words_o` is 0 whenever `valid_o` is high.
- R10: Mode values 101, 110 and 111, and size code 11, raise `illegal_o` for one cycle. In that case `valid_o` and `wb_en_o` stay low.
- R11: Pointer arithmetic wraps modulo 2^32.
- R12: `valid_o`, or else `illegal_o`, is high for exactly the one cycle after a start cycle. `wb_en_o` is high only in that same cycle. With no start, both strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 3 | Addressing mode code |
| reg_i | input | 3 | Register number |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| a_regs_i | input | 256 | Address registers 0..7, register n in bits [32n+31:32n] |
| valid_o | output | 1 | Result strobe |
| mem_o | output | 1 | 1: `addr_o` is a memory address; 0: operand is the register in `opnd_sel_o` |
| opnd_sel_o | output | 4 | {address-register flag, register number} |
| addr_o | output | 32 | Operand memory address (0 for register operands) |
| ext_words_o | output | 3 | Extension words consumed |
| illegal_o | output | 1 | Unsupported mode or size |
| wb_en_o | output | 1 | Pointer write enable |
| wb_reg_o | output | 3 | Pointer register number |
| wb_data_o | output | 32 | New pointer value |

## Verification
The assertions assume that the mode, register and size fields are stable during the start cycle. They also use `$past` on those fields, so the fields must not change between the start edge and the edge that samples the result. They assume that `a_regs_i` is read in the start cycle only. The bench drives every field together with the start strobe on a falling edge and holds it until the next falling edge. It keeps the register bus constant during table vectors, so the expected addresses in the table stay valid without a model of the register file.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned NUM_AREG  = 8;
  localparam int unsigned IDX_W     = $clog2(NUM_AREG);
  localparam int unsigned STACK_IDX = NUM_AREG - 1;
  localparam int unsigned EXT_W     = 3;

  localparam logic [2:0] MODE_DREG    = 3'd0;
  localparam logic [2:0] MODE_AREG    = 3'd1;
  localparam logic [2:0] MODE_IND     = 3'd2;
  localparam logic [2:0] MODE_POSTINC = 3'd3;
  localparam logic [2:0] MODE_PREDEC  = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } op_size_e;

  typedef struct packed {
    logic legal;
    logic is_mem;
    logic areg_sel;
    logic upd_en;
    logic upd_dec;
  } mode_ctl_t;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int unsigned EXT_BITS = EXT_W
) (
  input  logic [2:0]          mode,
  input  logic [1:0]          size,
  output mode_ctl_t           ctl,
  output logic [EXT_BITS-1:0] ext_cnt
);
  logic size_ok;

  always_comb begin
    size_ok = (size != SZ_BAD);
    ctl     = '0;
    ext_cnt = '0;
    unique case (mode)
      MODE_DREG: begin
        ctl.legal = size_ok;
      end
      MODE_AREG: begin
        ctl.legal    = size_ok;
        ctl.areg_sel = 1'b1;
      end
      MODE_IND: begin
        ctl.legal    = size_ok;
        ctl.is_mem   = 1'b1;
        ctl.areg_sel = 1'b1;
      end
      MODE_POSTINC: begin
        ctl.legal    = size_ok;
        ctl.is_mem   = 1'b1;
        ctl.areg_sel = 1'b1;
        ctl.upd_en   = 1'b1;
      end
      MODE_PREDEC: begin
        ctl.legal    = size_ok;
        ctl.is_mem   = 1'b1;
        ctl.areg_sel = 1'b1;
        ctl.upd_en   = 1'b1;
        ctl.upd_dec  = 1'b1;
      end
      default: begin
        ctl = '0;
      end
    endcase
  end
endmodule

// File: rtl/ea_step_calc.sv
module ea_step_calc
  import ea_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned IW     = IDX_W,
  parameter int unsigned SP_IDX = STACK_IDX
) (
  input  logic [IW-1:0] reg_idx,
  input  logic [1:0]    size,
  output logic [AW-1:0] step
);
  localparam logic [IW-1:0] SP_CODE = IW'(SP_IDX);

  logic is_sp;

  always_comb begin
    is_sp = (reg_idx == SP_CODE);
    unique case (size)
      SZ_BYTE: step = is_sp ? AW'(2) : AW'(1);
      SZ_WORD: step = AW'(2);
      SZ_LONG: step = AW'(4);
      default: step = AW'(4);
    endcase
  end
endmodule

// File: rtl/ea_addr_alu.sv
module ea_addr_alu #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic          dec,
  output logic [AW-1:0] issue_addr,
  output logic [AW-1:0] new_ptr
);
  logic [AW-1:0] sum;
  logic [AW-1:0] diff;

  always_comb begin
    sum  = base + step;
    diff = base - step;
    if (dec) begin
      new_ptr    = diff;
      issue_addr = diff;
    end else begin
      new_ptr    = sum;
      issue_addr = base;
    end
  end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NREG  = NUM_AREG,
  parameter int unsigned IW    = IDX_W,
  parameter int unsigned EXTW  = EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [IW-1:0]     reg_i,
  input  logic [1:0]        size_i,
  input  logic [NREG*AW-1:0] a_regs_i,
  output logic              valid_o,
  output logic              mem_o,
  output logic [IW:0]       opnd_sel_o,
  output logic [AW-1:0]     addr_o,
  output logic [EXTW-1:0]   ext_words_o,
  output logic              illegal_o,
  output logic              wb_en_o,
  output logic [IW-1:0]     wb_reg_o,
  output logic [AW-1:0]     wb_data_o
);
  localparam int unsigned SP_IDX = NREG - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // address register read
  logic [AW-1:0] areg [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign areg[g] = a_regs_i[g*AW +: AW];
  end

  logic [AW-1:0] base;
  assign base = areg[reg_i];

  // datapath pieces
  mode_ctl_t       ctl;
  logic [EXTW-1:0] ext_cnt;
  logic [AW-1:0]   step;
  logic [AW-1:0]   issue_addr;
  logic [AW-1:0]   new_ptr;

  ea_mode_decode #(.EXT_BITS(EXTW)) u_decode (
    .mode    (mode_i),
    .size    (size_i),
    .ctl     (ctl),
    .ext_cnt (ext_cnt)
  );

  ea_step_calc #(.AW(AW), .IW(IW), .SP_IDX(SP_IDX)) u_step (
    .reg_idx (reg_i),
    .size    (size_i),
    .step    (step)
  );

  ea_addr_alu #(.AW(AW)) u_alu (
    .base       (base),
    .step       (step),
    .dec        (ctl.upd_dec),
    .issue_addr (issue_addr),
    .new_ptr    (new_ptr)
  );

  // next state
  logic            valid_d, illegal_d, wb_en_d, mem_d;
  logic [IW:0]     sel_d;
  logic [AW-1:0]   addr_d, wb_data_d;
  logic [EXTW-1:0] ext_d;
  logic            load_en;

  always_comb begin
    load_en   = start_i;
    valid_d   = start_i &  ctl.legal;
    illegal_d = start_i & ~ctl.legal;
    wb_en_d   = start_i &  ctl.legal & ctl.upd_en;
    mem_d     = ctl.legal & ctl.is_mem;
    sel_d     = {ctl.areg_sel, reg_i};
    addr_d    = mem_d ? issue_addr : '0;
    wb_data_d = (ctl.legal && ctl.upd_en) ? new_ptr : base;
    ext_d     = ext_cnt;
  end

  // registers
  logic            valid_q, illegal_q, wb_en_q, mem_q;
  logic [IW:0]     sel_q;
  logic [AW-1:0]   addr_q, wb_data_q;
  logic [IW-1:0]   wb_reg_q;
  logic [EXTW-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      wb_en_q   <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      wb_en_q   <= wb_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mem_q     <= 1'b0;
      sel_q     <= '0;
      addr_q    <= '0;
      wb_reg_q  <= '0;
      wb_data_q <= '0;
      ext_q     <= '0;
    end else if (load_en) begin
      mem_q     <= mem_d;
      sel_q     <= sel_d;
      addr_q    <= addr_d;
      wb_reg_q  <= reg_i;
      wb_data_q <= wb_data_d;
      ext_q     <= ext_d;
    end
  end

  assign valid_o     = valid_q;
  assign illegal_o   = illegal_q;
  assign wb_en_o     = wb_en_q;
  assign mem_o       = mem_q;
  assign opnd_sel_o  = sel_q;
  assign addr_o      = addr_q;
  assign wb_reg_o    = wb_reg_q;
  assign wb_data_o   = wb_data_q;
  assign ext_words_o = ext_q;

  // assertions
  logic [AW-1:0] ptr_delta;
  assign ptr_delta = wb_data_o - addr_o;

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    start_i |=> (valid_o != illegal_o));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !start_i |=> (!valid_o && !illegal_o && !wb_en_o));

  assert_wb_with_valid_R12: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wb_en_o |-> (valid_o && mem_o));

  assert_ext_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_o |-> (ext_words_o == '0));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    illegal_o |-> (!valid_o && !wb_en_o));

  assert_direct_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (valid_o && !mem_o) |-> !wb_en_o);

  assert_predec_same_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (valid_o && wb_en_o && $past(mode_i) == MODE_PREDEC) |-> (addr_o == wb_data_o));

  assert_postinc_step_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (valid_o && wb_en_o && $past(mode_i) == MODE_POSTINC) |->
      (ptr_delta == AW'(1) || ptr_delta == AW'(2) || ptr_delta == AW'(4)));

  assert_sp_even_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (valid_o && wb_en_o && $past(mode_i) == MODE_POSTINC && $past(reg_i) == IW'(SP_IDX))
      |-> (ptr_delta != AW'(1)));
endmodule

// File: tb/ea_gen_unit_tb.sv
module ea_gen_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [2:0]   mode_i;
  logic [2:0]   reg_i;
  logic [1:0]   size_i;
  logic [255:0] a_regs_i;
  logic         valid_o, mem_o, illegal_o, wb_en_o;
  logic [3:0]   opnd_sel_o;
  logic [31:0]  addr_o, wb_data_o;
  logic [2:0]   ext_words_o, wb_reg_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ea_gen_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .reg_i(reg_i),
    .size_i(size_i), .a_regs_i(a_regs_i), .valid_o(valid_o), .mem_o(mem_o),
    .opnd_sel_o(opnd_sel_o), .addr_o(addr_o), .ext_words_o(ext_words_o),
    .illegal_o(illegal_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  rg;
    logic [1:0]  sz;
    logic        ev;
    logic        eill;
    logic        emem;
    logic [3:0]  esel;
    logic [31:0] eaddr;
    logic        ewb;
    logic [31:0] ewbd;
  } vec_t;

  // A0=1000 A1=FFFFFFFF A2=2001 A3=0 A4=12345678 A5=FFFE A6=80000000 A7=8000
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 4'h5, 32'h0,        1'b0, 32'h0},        // R2
    '{3'd1, 3'd2, 2'd2, 1'b1, 1'b0, 1'b0, 4'hA, 32'h0,        1'b0, 32'h0},        // R3
    '{3'd2, 3'd4, 2'd2, 1'b1, 1'b0, 1'b1, 4'hC, 32'h12345678, 1'b0, 32'h0},        // R4
    '{3'd3, 3'd0, 2'd0, 1'b1, 1'b0, 1'b1, 4'h8, 32'h00001000, 1'b1, 32'h00001001}, // R5 R7
    '{3'd3, 3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 4'h8, 32'h00001000, 1'b1, 32'h00001002}, // R7
    '{3'd3, 3'd0, 2'd2, 1'b1, 1'b0, 1'b1, 4'h8, 32'h00001000, 1'b1, 32'h00001004}, // R7
    '{3'd3, 3'd7, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 32'h00008000, 1'b1, 32'h00008002}, // R8
    '{3'd4, 3'd7, 2'd0, 1'b1, 1'b0, 1'b1, 4'hF, 32'h00007FFE, 1'b1, 32'h00007FFE}, // R8
    '{3'd4, 3'd7, 2'd2, 1'b1, 1'b0, 1'b1, 4'hF, 32'h00007FFC, 1'b1, 32'h00007FFC}, // R6
    '{3'd4, 3'd2, 2'd0, 1'b1, 1'b0, 1'b1, 4'hA, 32'h00002000, 1'b1, 32'h00002000}, // R6 R7
    '{3'd4, 3'd5, 2'd2, 1'b1, 1'b0, 1'b1, 4'hD, 32'h0000FFFA, 1'b1, 32'h0000FFFA}, // R6
    '{3'd3, 3'd1, 2'd0, 1'b1, 1'b0, 1'b1, 4'h9, 32'hFFFFFFFF, 1'b1, 32'h00000000}, // R11
    '{3'd4, 3'd3, 2'd1, 1'b1, 1'b0, 1'b1, 4'hB, 32'hFFFFFFFE, 1'b1, 32'hFFFFFFFE}, // R11
    '{3'd3, 3'd6, 2'd2, 1'b1, 1'b0, 1'b1, 4'hE, 32'h80000000, 1'b1, 32'h80000004}, // R5
    '{3'd5, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0,        1'b0, 32'h0},        // R10
    '{3'd6, 3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0,        1'b0, 32'h0},        // R10
    '{3'd7, 3'd7, 2'd2, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0,        1'b0, 32'h0},        // R10
    '{3'd2, 3'd0, 2'd3, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0,        1'b0, 32'h0}         // R10
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s);
    @(negedge clk);
    mode_i  = m;
    reg_i   = r;
    size_i  = s;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    mode_i  = '0;
    reg_i   = '0;
    size_i  = '0;
    a_regs_i = {32'h00008000, 32'h80000000, 32'h0000FFFE, 32'h12345678,
                32'h00000000, 32'h00002001, 32'hFFFFFFFF, 32'h00001000};
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset",   {31'b0, valid_o},   32'd0);
    chk("R1", "illegal in reset", {31'b0, illegal_o}, 32'd0);
    chk("R1", "wb_en in reset",   {31'b0, wb_en_o},   32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after release", {31'b0, valid_o}, 32'd0);
    repeat (3) @(negedge clk);

    // idle: no strobes without start (R12)
    chk("R12", "valid idle", {31'b0, valid_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].mode, VECS[i].rg, VECS[i].sz);
      chk("R12 vec", "valid",   {31'b0, valid_o},   {31'b0, VECS[i].ev});
      chk("R10 vec", "illegal", {31'b0, illegal_o}, {31'b0, VECS[i].eill});
      chk("R5 vec",  "wb_en",   {31'b0, wb_en_o},   {31'b0, VECS[i].ewb});
      if (VECS[i].ev) begin
        chk("R2 vec", "mem",       {31'b0, mem_o},      {31'b0, VECS[i].emem});
        chk("R3 vec", "opnd_sel",  {28'b0, opnd_sel_o}, {28'b0, VECS[i].esel});
        chk("R9",     "ext_words", {29'b0, ext_words_o}, 32'd0);
        if (VECS[i].emem) chk("R4 vec", "addr", addr_o, VECS[i].eaddr);
        if (VECS[i].ewb) begin
          chk("R6 vec", "wb_data", wb_data_o, VECS[i].ewbd);
          chk("R5 vec", "wb_reg",  {29'b0, wb_reg_o}, {29'b0, VECS[i].rg});
        end
      end
      @(negedge clk);
      chk("R12", "single pulse", {29'b0, valid_o, illegal_o, wb_en_o}, 32'd0);
    end

    // back-to-back starts with a changed register bus (R12, R8)
    @(negedge clk);
    mode_i = 3'd4; reg_i = 3'd7; size_i = 2'd0; start_i = 1'b1;
    a_regs_i[255:224] = 32'h00000001;
    @(negedge clk);
    chk("R8", "sp byte predec wrap", addr_o, 32'hFFFFFFFF);
    mode_i = 3'd3; reg_i = 3'd3; size_i = 2'd1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R12", "second valid", {31'b0, valid_o}, 32'd1);
    chk("R7", "word postinc from 0", wb_data_o, 32'h00000002);

    // reset in the middle of a request (R1)
    @(negedge clk);
    mode_i = 3'd3; reg_i = 3'd0; size_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "async clear", {29'b0, valid_o, illegal_o, wb_en_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "quiet after reset", {29'b0, valid_o, illegal_o, wb_en_o}, 32'd0);

    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule